// File: doc/BRIEF.md
# Raster Cursor Overlay

This block paints a small monochrome pointer shape over a live pixel stream. A shape store of up to 128 rows holds 64 one-bit pixels per row, packed as two 32-bit words per row. Software loads it through a word-address register followed by a data port whose address steps forward by one after every write. A placement register sets the top-left corner of the shape on the raster and holds the on/off flag in its top bit. A 24-bit RGB register sets the colour in which set shape bits are drawn.

On every pixel clock the block takes the raster X/Y, the underlying 24-bit pixel and the sync and active qualifiers. Wherever the raster falls inside the enabled shape window and the matching shape bit is one, the pixel is replaced by the cursor colour. Everywhere else the pixel passes through unchanged. Output pixel, sync and active all leave one clock after they arrive.

Top module: `cursor_overlay`

## Requirements
- R1: During reset and in the first cycle after it, `pix_out`, `sync_out` and `active_out` are zero. The overlay starts disabled, so after reset every pixel passes through unchanged.
- R2: A configuration write with `cfg_sel` = 0 loads the word address from `cfg_wdata[7:0]`. The other selects are: 1 is the data port, 2 is placement and 3 is colour.
- R3: A write with `cfg_sel` = 1 stores `cfg_wdata` at the current word address and then adds one to the address. The address wraps from 255 to 0.
- R4: Shape row r occupies words 2r and 2r+1. Word 2r covers window columns 0 to 31 and word 2r+1 covers columns 32 to 63.
- R5: Inside a word, byte 0 (bits 7:0) holds the leftmost eight columns, and within each byte bit 7 is the leftmost column. Column c of a word is therefore bit 8*(c/8) + 7 - (c mod 8).
- R6: The placement word carries the enable in bit 31, the window X in bits 30:16 and the window Y in bits 15:0. Bit 31 never adds to X.
- R7: The colour word carries red in bits 23:16, green in 15:8 and blue in 7:0. A set shape bit puts exactly this 24-bit value on `pix_out`.
- R8: The window spans columns X to X+63 and rows Y to Y+LINES-1. Outside the window, on a clear shape bit, or while disabled, `pix_out` equals `pix_in`.
- R9: `pix_out`, `sync_out` and `active_out` reflect the inputs of the previous clock, so all three share one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 address, 1 data, 2 placement, 3 colour |
| cfg_wdata | input | 32 | Configuration write data |
| raster_x | input | 16 | Current raster column |
| raster_y | input | 16 | Current raster row |
| pix_in | input | 24 | Underlying RGB pixel |
| sync_in | input | 2 | Sync qualifiers, delayed with the pixel |
| active_in | input | 1 | Active-video qualifier |
| pix_out | output | 24 | Merged RGB pixel |
| sync_out | output | 2 | Delayed sync qualifiers |
| active_out | output | 1 | Delayed active qualifier |

## Verification
The bench builds the block with its default of 128 rows, so the shape store is a full 256 words. That size brings the address wrap from 255 back to 0 within reach, and it puts the last row of the window and the first row below it on either side of the Y bound. The 16-bit coordinates let the window sit at the top of the 15-bit X field with a Y near the top of its range. That placement shows that the enable bit stays out of the X compare.

// File: rtl/cursor_pkg.sv
// Shared types and fixed widths for the cursor overlay.
// Assumes a 32-bit configuration bus and 16-bit raster coordinates.
package cursor_pkg;
    localparam int WORD_W    = 32;
    localparam int COORD_W   = 16;
    localparam int RGB_W     = 24;
    localparam int SYNC_W    = 2;
    localparam int WORDS_ROW = 2;
    localparam int ROW_PIX   = WORD_W * WORDS_ROW;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_DATA  = 2'd1,
        SEL_PLACE = 2'd2,
        SEL_COLOR = 2'd3
    } cfg_sel_e;

    typedef logic [RGB_W-1:0] rgb_t;
endpackage

// File: rtl/cursor_cfg_regs.sv
// Configuration registers for the overlay: the auto-stepping word address,
// the placement/enable word and the colour word.
// Assumes one write per strobe cycle. The word address wraps modulo the store size.
module cursor_cfg_regs
    import cursor_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [WORD_W-1:0]    cfg_wdata,
    output logic                 store_we,
    output logic [ADDR_W-1:0]    store_addr,
    output logic                 cur_en,
    output logic [COORD_W-2:0]   cur_x,
    output logic [COORD_W-1:0]   cur_y,
    output rgb_t                 cur_color
);
    cfg_sel_e sel;
    logic [ADDR_W-1:0] addr_q;

    assign sel        = cfg_sel_e'(cfg_sel);
    assign store_we   = cfg_we && (sel == SEL_DATA);
    assign store_addr = addr_q;

    // Word address: loaded by an address write, stepped by a data write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (cfg_we && sel == SEL_ADDR)
            addr_q <= cfg_wdata[ADDR_W-1:0];
        else if (store_we)
            addr_q <= addr_q + 1'b1;
    end

    // Placement word: enable in the top bit, X below it, Y in the low half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_en <= 1'b0;
            cur_x  <= '0;
            cur_y  <= '0;
        end else if (cfg_we && sel == SEL_PLACE) begin
            cur_en <= cfg_wdata[WORD_W-1];
            cur_x  <= cfg_wdata[WORD_W-2:COORD_W];
            cur_y  <= cfg_wdata[COORD_W-1:0];
        end
    end

    // Colour word: 24-bit RGB.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_color <= '0;
        else if (cfg_we && sel == SEL_COLOR)
            cur_color <= cfg_wdata[RGB_W-1:0];
    end

    // R2: an address write sets the address seen in the next cycle.
    a_r2_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd0) |=> (addr_q == $past(cfg_wdata[ADDR_W-1:0])));

    // R3: a data write steps the address by one, with wrap.
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd1) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));
endmodule

// File: rtl/cursor_shape_store.sv
// Shape memory: one synchronous write port and one asynchronous read port.
// Assumes that no reset of contents is needed, because software loads the
// store before it enables the overlay.
module cursor_shape_store
    import cursor_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Store one word per data-port write.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/cursor_mixer.sv
// Window test, shape-bit pick and registered merge of the cursor colour.
// Assumes 64 columns per row (two words) and a one-clock output stage.
module cursor_mixer
    import cursor_pkg::*;
#(
    parameter int LINES  = 128,
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] raster_x,
    input  logic [COORD_W-1:0] raster_y,
    input  rgb_t               pix_in,
    input  logic [SYNC_W-1:0]  sync_in,
    input  logic               active_in,
    input  logic               cur_en,
    input  logic [COORD_W-2:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  rgb_t               cur_color,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic [WORD_W-1:0]  rd_data,
    output rgb_t               pix_out,
    output logic [SYNC_W-1:0]  sync_out,
    output logic               active_out
);
    localparam int ROW_W  = ADDR_W - 1;
    localparam int HALF_B = $clog2(WORD_W);

    logic [COORD_W-1:0] x_base, dx, dy;
    logic               in_x, in_y, hit;
    logic [HALF_B-1:0]  bit_sel;

    assign x_base = {1'b0, cur_x};
    assign dx     = raster_x - x_base;
    assign dy     = raster_y - cur_y;

    // Window test for the current raster position.
    always_comb begin
        in_x = (raster_x >= x_base) && (dx < COORD_W'(ROW_PIX));
        in_y = (raster_y >= cur_y)  && (dy < COORD_W'(LINES));
    end

    // Word pick from row and half, bit pick with byte 0 leftmost and MSB first.
    assign rd_addr = {dy[ROW_W-1:0], dx[HALF_B]};
    assign bit_sel = {dx[HALF_B-1:3], ~dx[2:0]};
    assign hit     = cur_en && in_x && in_y && rd_data[bit_sel];

    // Output stage: merged pixel plus qualifiers, one clock of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out    <= '0;
            sync_out   <= '0;
            active_out <= 1'b0;
        end else begin
            pix_out    <= hit ? cur_color : pix_in;
            sync_out   <= sync_in;
            active_out <= active_in;
        end
    end

    // R8: while disabled the pixel passes through unchanged.
    a_r8_off_passes: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_en |=> (pix_out == $past(pix_in)));

    // R7: a shape hit shows the colour register value.
    a_r7_hit_color: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (pix_out == $past(cur_color)));

    // R8: outside the window the pixel passes through unchanged.
    a_r8_outside_passes: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_x && in_y) |=> (pix_out == $past(pix_in)));
endmodule

// File: rtl/cursor_overlay.sv
// Top of the cursor overlay: configuration registers, shape store and mixer.
// Assumes that configuration writes and the pixel stream share one clock.
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int LINES = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [WORD_W-1:0]   cfg_wdata,
    input  logic [COORD_W-1:0]  raster_x,
    input  logic [COORD_W-1:0]  raster_y,
    input  logic [RGB_W-1:0]    pix_in,
    input  logic [SYNC_W-1:0]   sync_in,
    input  logic                active_in,
    output logic [RGB_W-1:0]    pix_out,
    output logic [SYNC_W-1:0]   sync_out,
    output logic                active_out
);
    localparam int DEPTH  = LINES * WORDS_ROW;
    localparam int ADDR_W = $clog2(DEPTH);

    logic               store_we, cur_en;
    logic [ADDR_W-1:0]  store_addr, rd_addr;
    logic [COORD_W-2:0] cur_x;
    logic [COORD_W-1:0] cur_y;
    rgb_t               cur_color;
    logic [WORD_W-1:0]  rd_data;

    cursor_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .store_we(store_we), .store_addr(store_addr),
        .cur_en(cur_en), .cur_x(cur_x), .cur_y(cur_y), .cur_color(cur_color)
    );

    cursor_shape_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .wr_en(store_we), .wr_addr(store_addr), .wr_data(cfg_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    cursor_mixer #(.LINES(LINES), .ADDR_W(ADDR_W)) u_mix (
        .clk(clk), .rst_n(rst_n), .raster_x(raster_x), .raster_y(raster_y),
        .pix_in(pix_in), .sync_in(sync_in), .active_in(active_in),
        .cur_en(cur_en), .cur_x(cur_x), .cur_y(cur_y), .cur_color(cur_color),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .pix_out(pix_out), .sync_out(sync_out), .active_out(active_out)
    );

    // R9: the qualifiers leave together one clock after the pixel inputs.
    a_r9_qual_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_in) |=> $rose(active_out));
endmodule

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
    localparam int LINES = 128;
    localparam int NVEC  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] raster_x = '0, raster_y = '0;
    logic [23:0] pix_in = '0;
    logic [1:0]  sync_in = '0;
    logic        active_in = 1'b0;
    logic [23:0] pix_out;
    logic [1:0]  sync_out;
    logic        active_out;

    int checks = 0, fails = 0;
    logic [31:0] img [256];
    logic        m_en = 1'b0;
    logic [14:0] m_x = '0;
    logic [15:0] m_y = '0;
    logic [23:0] m_col = '0;

    always #10 clk = ~clk;

    cursor_overlay #(.LINES(LINES)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .raster_x(raster_x), .raster_y(raster_y),
        .pix_in(pix_in), .sync_in(sync_in), .active_in(active_in),
        .pix_out(pix_out), .sync_out(sync_out), .active_out(active_out)
    );

    // stimulus vectors: {x, y, pixel}
    typedef struct packed { logic [15:0] x; logic [15:0] y; logic [23:0] p; } vec_t;
    localparam vec_t VEC [NVEC] = '{
        '{16'd100, 16'd50,  24'h010203}, '{16'd163, 16'd50,  24'h040506},
        '{16'd164, 16'd50,  24'h070809}, '{16'd99,  16'd50,  24'h0A0B0C},
        '{16'd100, 16'd177, 24'h0D0E0F}, '{16'd100, 16'd178, 24'h101112},
        '{16'd131, 16'd60,  24'h131415}, '{16'd132, 16'd61,  24'h161718},
        '{16'd120, 16'd100, 24'h191A1B}, '{16'd150, 16'd49,  24'h1C1D1E},
        '{16'd140, 16'd130, 24'h1F2021}, '{16'd110, 16'd90,  24'h222324}
    };

    function automatic logic [23:0] model(input logic [15:0] x, input logic [15:0] y,
                                          input logic [23:0] p);
        int ox, oy, c;
        logic [31:0] w;
        ox = int'(x) - int'(m_x);
        oy = int'(y) - int'(m_y);
        if (!m_en || ox < 0 || ox > 63 || oy < 0 || oy >= LINES) return p;
        w = img[oy*2 + ox/32];
        c = ox % 32;
        return w[(c/8)*8 + 7 - (c%8)] ? m_col : p;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic place(input logic en, input logic [14:0] x, input logic [15:0] y);
        wr(2'd2, {en, x, y});
        m_en = en; m_x = x; m_y = y;
    endtask

    task automatic probe(input logic [15:0] x, input logic [15:0] y, input logic [23:0] p,
                         input string req);
        logic [23:0] e;
        @(negedge clk);
        raster_x = x; raster_y = y; pix_in = p;
        e = model(x, y, p);
        @(negedge clk);
        check(pix_out == e, req, 32'(pix_out), 32'(e));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: outputs cleared during reset
        pix_in = 24'hFFFFFF; sync_in = 2'b11; active_in = 1'b1;
        repeat (3) @(negedge clk);
        check(pix_out == 0 && sync_out == 0 && active_out == 0, "R1 reset outputs",
              {5'd0, active_out, sync_out, pix_out}, 32'd0);
        rst_n = 1'b1;
        sync_in = 2'b00; active_in = 1'b0;
        // R1: disabled after reset, so the pixel passes
        probe(16'd0, 16'd0, 24'hABCDEF, "R1 passthrough after reset");

        // R3: load the whole store through the stepping port
        wr(2'd0, 32'd0);
        for (int i = 0; i < 256; i++) begin
            img[i] = 32'h9E3779B9 * (i + 1);
            wr(2'd1, img[i]);
        end
        wr(2'd3, 32'hFF12AB34);
        m_col = 24'h12AB34;
        place(1'b1, 15'd100, 16'd50);

        // R4 R5 R7 R8 R9: vector walk with qualifiers
        for (int v = 0; v < NVEC; v++) begin
            logic [23:0] e;
            @(negedge clk);
            raster_x = VEC[v].x; raster_y = VEC[v].y; pix_in = VEC[v].p;
            sync_in = 2'(v); active_in = v[0];
            e = model(VEC[v].x, VEC[v].y, VEC[v].p);
            @(negedge clk);
            check(pix_out == e, "R4 R7 R8 vector pixel", 32'(pix_out), 32'(e));
            check(sync_out == 2'(v) && active_out == v[0], "R9 qualifier delay",
                  {29'd0, active_out, sync_out}, {29'd0, v[0], 2'(v)});
        end

        // R6: enable cleared, same placement, passes through
        place(1'b0, 15'd100, 16'd50);
        probe(16'd100, 16'd50, 24'h00FF00, "R6 disable bit");
        place(1'b1, 15'd100, 16'd50);

        // R2: address write selects row 1 left word; R5 bit order
        wr(2'd0, 32'd2);
        wr(2'd1, 32'h0000_0080); img[2] = 32'h0000_0080;
        probe(16'd100, 16'd51, 24'h111111, "R2 address load");
        probe(16'd101, 16'd51, 24'h222222, "R5 byte0 msb only");
        wr(2'd0, 32'd0);
        wr(2'd1, 32'h0000_0100); img[0] = 32'h0000_0100;
        probe(16'd115, 16'd50, 24'h333333, "R5 byte1 lsb column 15");
        probe(16'd108, 16'd50, 24'h444444, "R5 byte1 msb clear");

        // R3: wrap from 255 to 0
        wr(2'd0, 32'd255);
        wr(2'd1, 32'h8000_0000); img[255] = 32'h8000_0000;
        wr(2'd1, 32'h0000_0001); img[0] = 32'h0000_0001;
        probe(16'd156, 16'd177, 24'h555555, "R3 last word");
        probe(16'd107, 16'd50, 24'h666666, "R3 wrapped word");
        probe(16'd115, 16'd50, 24'h777777, "R3 old bit overwritten");

        // R6: X at the top of its field, enable bit kept out of X
        place(1'b1, 15'h7FC0, 16'hFF00);
        probe(16'h7FC7, 16'hFF00, 24'h888888, "R6 high X");
        probe(16'hFFC7, 16'hFF00, 24'h999999, "R6 bit31 not in X");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule